// File: doc/BRIEF.md
# OTP Status-Byte Write Sequencer

This block runs the byte-level side of writing status bytes into a one-time-programmable store. A bit-timing front end, which is not part of this block, turns the single-wire bus into single-cycle strobes: a bus reset, a received byte, a request to read one byte, and a programming pulse. The sequencer decodes a command byte, then takes a 16-bit start address and a data byte. It keeps a running CRC-16, returns it to the master when asked, and programs the byte when a programming pulse arrives. It then returns the stored byte so the master can check it.

After the stored byte has been read, the address steps forward by one. The next data byte can then follow at once, with the CRC reseeded from the new address. There are two command variants. The checked variant returns the CRC before every programming pulse. The speed variant skips that CRC read. Programming can only clear bits, so each stored byte is the AND of everything ever written to it. The block never compares CRCs itself. The master decides whether to send the programming pulse.

Top module: `otp_status_writer`

## Requirements
- R1: Command byte 55H starts the checked flow and F5H starts the speed flow. Any other command byte puts the block in a mute state until the next bus reset: later bytes and programming pulses change nothing, and reads return FFH.
- R2: For the first byte after the command, the CRC starts at zero. The command byte, the address low byte, the address high byte and the data byte are shifted in, in that order. Each byte goes in bit 0 first, using the reflected polynomial x^16+x^15+x^2+1 (constant A001H applied after a right shift).
- R3: For every later byte, the CRC register is loaded with the incremented 16-bit address, and only the new data byte is shifted in.
- R4: In the checked flow, after the data byte, the next two reads return the bitwise inverse of the CRC, low byte first and then high byte.
- R5: In the speed flow, no CRC is offered. The block waits for the programming pulse straight after the data byte, and a read in that wait returns FFH.
- R6: Every status cell powers up as FFH. A programming pulse sets the selected cell to its old value AND the data byte, so bits only ever fall.
- R7: The read that follows programming returns the stored cell value. This value may differ from the data byte.
- R8: After that verify read, the address increments by one modulo 2^16, whether or not the stored value matched. The block then waits for the next data byte.
- R9: The cell index is the address modulo the array depth (the low address bits). The depth is 32 by default and must be a power of two.
- R10: A bus reset at any point ends the sequence and returns the block to waiting for a command.
- R11: A programming pulse outside the wait-for-pulse state has no effect. A received byte in a state that does not expect one is ignored.
- R12: Every read request yields tx_valid in the next cycle. When the current state offers no data, the byte returned is FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset; cells return to FFH |
| bus_reset | input | 1 | Single-cycle bus reset strobe, aborts the sequence |
| rx_valid | input | 1 | Strobe: rx_byte holds a byte sent by the master |
| rx_byte | input | 8 | Byte from the master |
| rd_req | input | 1 | Strobe: the master reads one byte |
| prog_pulse | input | 1 | Programming pulse strobe |
| tx_valid | output | 1 | Read response valid, one cycle after rd_req |
| tx_byte | output | 8 | Read response byte |

## Verification
The bench goes after the reseeding of the CRC on later bytes. A design that kept shifting the address, or that seeded from the old address, would return a wrong CRC on the second byte. It writes a second value over an already-programmed cell, so a design that overwrites instead of ANDing shows up in the verify byte. The bench also starts at address FFFFH to catch a counter that fails to wrap to zero. It starts at an address beyond the array to catch a design that ignores the modulo. It sends programming pulses in the wrong state, after a bus reset and after an unknown command. It reads the cell back afterwards, so a block that programs anyway would show the damaged cell. In the speed flow it probes for FFH where a wrong design would still offer a CRC byte.

// File: rtl/otp_sw_pkg.sv
package otp_sw_pkg;

    localparam logic [7:0]  CMD_CHECKED = 8'h55;
    localparam logic [7:0]  CMD_SPEED   = 8'hF5;
    localparam logic [15:0] CRC_POLY    = 16'hA001;
    localparam logic [7:0]  IDLE_BYTE   = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_DATA,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_PROG,
        ST_VERIFY,
        ST_MUTE
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic        checked;
        logic [15:0] addr;
        logic [15:0] crc;
        logic [7:0]  data;
        logic        tx_valid;
        logic [7:0]  tx_byte;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:    ST_IDLE,
        checked:  1'b0,
        addr:     16'h0000,
        crc:      16'h0000,
        data:     8'h00,
        tx_valid: 1'b0,
        tx_byte:  IDLE_BYTE
    };

endpackage

// File: rtl/otp_crc16_byte.sv
module otp_crc16_byte
    import otp_sw_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic [15:0]     seed,
    input  logic [BITS-1:0] din,
    output logic [15:0]     result
);
    always_comb begin
        logic [15:0] acc;
        logic        fb;
        acc = seed;
        for (int i = 0; i < BITS; i++) begin
            fb  = acc[0] ^ din[i];
            acc = {1'b0, acc[15:1]};
            if (fb) begin
                acc = acc ^ CRC_POLY;
            end
        end
        result = acc;
    end
endmodule

// File: rtl/otp_status_array.sv
module otp_status_array
    import otp_sw_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    logic [7:0] cells_q [DEPTH];
    logic [7:0] cells_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cells_d[i] = cells_q[i];
            if (wr_en && (wr_idx == AW'(i))) begin
                cells_d[i] = cells_q[i] & wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= IDLE_BYTE;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= cells_d[i];
            end
        end
    end

    assign rd_data = cells_q[rd_idx];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell_chk
            // Bits of a cell never rise after power-up (R6)
            assert_bits_only_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((cells_q[g] & ~$past(cells_q[g])) == 8'h00));
            // Without a write strobe no cell changes (R11)
            assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(cells_q[g]));
        end
    endgenerate
endmodule

// File: rtl/otp_seq_ctrl.sv
module otp_seq_ctrl
    import otp_sw_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_reset,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rd_req,
    input  logic          prog_pulse,
    input  logic [7:0]    cell_rd_data,
    output logic          cell_wr_en,
    output logic [AW-1:0] cell_idx,
    output logic [7:0]    cell_wr_data,
    output logic          tx_valid,
    output logic [7:0]    tx_byte
);
    seq_regs_t   r_q, r_d;
    logic [15:0] crc_seed;
    logic [15:0] crc_shifted;
    logic [15:0] addr_inc;

    assign crc_seed = (r_q.state == ST_IDLE) ? 16'h0000 : r_q.crc;
    assign addr_inc = r_q.addr + 16'd1;

    otp_crc16_byte #(.BITS(8)) u_crc (
        .seed   (crc_seed),
        .din    (rx_byte),
        .result (crc_shifted)
    );

    always_comb begin
        r_d          = r_q;
        r_d.tx_valid = rd_req;
        r_d.tx_byte  = IDLE_BYTE;
        cell_wr_en   = 1'b0;
        if (bus_reset) begin
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (rx_valid) begin
                        r_d.crc = crc_shifted;
                        if (rx_byte == CMD_CHECKED) begin
                            r_d.state   = ST_ADDR_LO;
                            r_d.checked = 1'b1;
                        end else if (rx_byte == CMD_SPEED) begin
                            r_d.state   = ST_ADDR_LO;
                            r_d.checked = 1'b0;
                        end else begin
                            r_d.state = ST_MUTE;
                        end
                    end
                end
                ST_ADDR_LO: begin
                    if (rx_valid) begin
                        r_d.addr[7:0] = rx_byte;
                        r_d.crc       = crc_shifted;
                        r_d.state     = ST_ADDR_HI;
                    end
                end
                ST_ADDR_HI: begin
                    if (rx_valid) begin
                        r_d.addr[15:8] = rx_byte;
                        r_d.crc        = crc_shifted;
                        r_d.state      = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (rx_valid) begin
                        r_d.data  = rx_byte;
                        r_d.crc   = crc_shifted;
                        r_d.state = r_q.checked ? ST_CRC_LO : ST_PROG;
                    end
                end
                ST_CRC_LO: begin
                    if (rd_req) begin
                        r_d.tx_byte = ~r_q.crc[7:0];
                        r_d.state   = ST_CRC_HI;
                    end
                end
                ST_CRC_HI: begin
                    if (rd_req) begin
                        r_d.tx_byte = ~r_q.crc[15:8];
                        r_d.state   = ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (prog_pulse) begin
                        cell_wr_en = 1'b1;
                        r_d.state  = ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (rd_req) begin
                        r_d.tx_byte = cell_rd_data;
                        r_d.addr    = addr_inc;
                        r_d.crc     = addr_inc;
                        r_d.state   = ST_DATA;
                    end
                end
                ST_MUTE: begin
                end
                default: begin
                    r_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign cell_idx     = r_q.addr[AW-1:0];
    assign cell_wr_data = r_q.data;
    assign tx_valid     = r_q.tx_valid;
    assign tx_byte      = r_q.tx_byte;

    // Every read request is answered in the next cycle (R12)
    assert_read_answered_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> tx_valid);
    assert_no_spurious_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !tx_valid);
    // Bus reset always returns to command wait (R10)
    assert_reset_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (r_q.state == ST_IDLE));
    // Verify read steps the address by one (R8)
    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_VERIFY && rd_req && !bus_reset) |=> (r_q.addr == $past(r_q.addr) + 16'd1));
    // Next-byte CRC seeded by loading the new address (R3)
    assert_crc_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_VERIFY && rd_req && !bus_reset) |=> (r_q.crc == r_q.addr));
    // Writes only leave the pulse-wait state (R11)
    assert_write_leaves_prog_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cell_wr_en |=> (r_q.state == ST_VERIFY));
    // A mute block stays mute until bus reset (R1)
    assert_mute_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_MUTE && !bus_reset) |=> (r_q.state == ST_MUTE));
endmodule

// File: rtl/otp_status_writer.sv
module otp_status_writer
    import otp_sw_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_req,
    input  logic       prog_pulse,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    logic          wr_en;
    logic [AW-1:0] idx;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;

    otp_seq_ctrl #(.DEPTH(DEPTH)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset    (bus_reset),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rd_req       (rd_req),
        .prog_pulse   (prog_pulse),
        .cell_rd_data (rd_data),
        .cell_wr_en   (wr_en),
        .cell_idx     (idx),
        .cell_wr_data (wr_data),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte)
    );

    otp_status_array #(.DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );
endmodule

// File: tb/otp_status_writer_bench.sv
module otp_status_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic       prog_pulse = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    logic [7:0]  mem_m [DEPTH];
    logic [15:0] m_addr;
    logic [15:0] m_crc;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_status_writer #(.DEPTH(DEPTH)) u_otp_status_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rd_req     (rd_req),
        .prog_pulse (prog_pulse),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte)
    );

    function automatic logic [15:0] crc_model(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        x = c;
        for (int i = 0; i < 8; i++) begin
            if ((x[0] ^ b[i]) == 1'b1) x = (x >> 1) ^ 16'hA001;
            else                      x = x >> 1;
        end
        return x;
    endfunction

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected response: actual=%02h expected=none", tx_byte);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (tx_byte !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", t, tx_byte, e);
                end
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic pulse_prog();
        @(negedge clk);
        prog_pulse = 1'b1;
        @(negedge clk);
        prog_pulse = 1'b0;
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic start(input logic [7:0] cmd, input logic [15:0] a);
        m_crc = crc_model(16'h0000, cmd);
        send(cmd);
        m_crc = crc_model(m_crc, a[7:0]);
        send(a[7:0]);
        m_crc = crc_model(m_crc, a[15:8]);
        send(a[15:8]);
        m_addr = a;
    endtask

    task automatic data_step(input logic [7:0] d, input bit checked, input string crc_tag,
                             input string ver_tag);
        int idx;
        send(d);
        m_crc = crc_model(m_crc, d);
        if (checked) begin
            rd_expect(~m_crc[7:0],  {crc_tag, " crc low"});
            rd_expect(~m_crc[15:8], {crc_tag, " crc high"});
        end
        pulse_prog();
        idx = int'(m_addr) % DEPTH;
        mem_m[idx] = mem_m[idx] & d;
        rd_expect(mem_m[idx], ver_tag);
        m_addr = m_addr + 16'd1;
        m_crc  = m_addr;
    endtask

    // Driver
    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        checks++;
        if (tx_valid !== 1'b0 || tx_byte !== 8'hFF) begin
            errors++;
            $display("FAIL R12 reset state: actual=%0b/%02h expected=0/ff", tx_valid, tx_byte);
        end
        rst_n = 1'b1;
        @(negedge clk);
        rd_expect(8'hFF, "R12 idle read");

        // Checked flow, two bytes (R2, R3, R4, R7, R8)
        start(8'h55, 16'h0003);
        data_step(8'hA5, 1'b1, "R2 R4 first byte", "R7 R6 verify A5");
        data_step(8'h3C, 1'b1, "R3 R4 reseeded byte", "R7 R8 verify next cell");
        pulse_bus_reset();

        // AND programming over an existing cell; mismatching verify still advances (R6, R8)
        start(8'h55, 16'h0003);
        data_step(8'h0F, 1'b1, "R2 rewrite", "R6 R7 AND result");
        data_step(8'hF0, 1'b1, "R8 R3 advance after mismatch", "R7 cell 4 AND");
        pulse_bus_reset();

        // Speed flow: no CRC offered (R5)
        start(8'hF5, 16'h0010);
        send(8'h55);
        m_crc = crc_model(m_crc, 8'h55);
        rd_expect(8'hFF, "R5 no crc in speed flow");
        pulse_prog();
        mem_m[16] = mem_m[16] & 8'h55;
        rd_expect(mem_m[16], "R5 R7 speed verify");
        m_addr = 16'h0011;
        m_crc  = m_addr;
        data_step(8'hF0, 1'b0, "", "R5 R8 speed second byte");
        pulse_bus_reset();

        // Address beyond array wraps to cell 1 (R9)
        start(8'hF5, 16'h0021);
        data_step(8'hC3, 1'b0, "", "R9 wrapped write");
        pulse_bus_reset();
        start(8'h55, 16'h0001);
        data_step(8'hFF, 1'b1, "R9 R2 readback crc", "R9 cell 1 holds value");
        pulse_bus_reset();

        // 16-bit address rollover (R8)
        start(8'h55, 16'hFFFF);
        data_step(8'h7E, 1'b1, "R2 top address", "R9 verify top cell");
        data_step(8'h81, 1'b1, "R8 R3 seed after rollover", "R8 cell 0 after rollover");
        pulse_bus_reset();

        // Unknown command mutes the block (R1)
        start(8'h33, 16'h0002);
        send(8'h00);
        pulse_prog();
        rd_expect(8'hFF, "R1 mute read");
        pulse_bus_reset();
        start(8'h55, 16'h0002);
        data_step(8'hFF, 1'b1, "R1 check crc", "R1 cell 2 untouched by mute");
        pulse_bus_reset();

        // Programming pulse before CRC read is ignored; bus reset aborts (R11, R10)
        start(8'h55, 16'h0005);
        send(8'h00);
        pulse_prog();
        m_crc = crc_model(m_crc, 8'h00);
        rd_expect(~m_crc[7:0], "R11 crc after early pulse");
        pulse_bus_reset();
        pulse_prog();
        rd_expect(8'hFF, "R10 idle after abort");
        start(8'h55, 16'h0005);
        data_step(8'hFF, 1'b1, "R10 check crc", "R10 R11 cell 5 untouched");
        pulse_bus_reset();

        // Byte received while waiting for pulse is ignored (R11)
        start(8'hF5, 16'h0006);
        send(8'hE7);
        m_crc = crc_model(m_crc, 8'hE7);
        send(8'h00);
        pulse_prog();
        mem_m[6] = mem_m[6] & 8'hE7;
        rd_expect(mem_m[6], "R11 stray byte ignored");
        pulse_bus_reset();

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12 missing responses: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule